// File: doc/BRIEF.md
# Redial and Save Digit Buffer

This block sits between a debounced keypad and a telephone dialing engine. Each dialable key pressed during a call is recorded in a 32-entry redial store and queued for the engine. The engine takes one entry at a time, either as a digit or as a pause request, and acknowledges it with `dial_done`. A redial/pause key pressed as the very first key of a call replays the previous call's entries. A save key copies the current number into a second 32-entry store, and a recall key replays that store.

The raw hook level goes through an on-hook filter, so short high glitches do not end a call. Off-hook is taken at once. A new off-hook moves the last call's length and pause setting aside and rewinds the write pointer. A first-key redial therefore still finds the old entries in place. In pulse signalling, a star/T entry is turned into a pause, and the digits that follow go out as tone. This tone latch holds until the next recognised on-hook. Tone synthesis, pulse timing and flash handling belong to the engine.

Top module: `rdb_redial_buf`

## Requirements
- R1: After reset the block is in the on-hook state and both `out_vld` and `pause_req` are low.
- R2: On-hook is recognised only after `hook_raw` has been high for HOOK_DB_CYC consecutive cycles. A shorter high pulse leaves the call running.
- R3: Key codes 0 to 9 (digits) and 11 (hash) pressed off-hook are passed to the engine in key order, one entry each, on `out_vld` with `out_code` equal to the key code. No further entry is issued until `dial_done` has been seen after the previous one.
- R4: Key 12 or 13 pressed as the first key after off-hook replays every entry of the previous call, in order.
- R5: A call that stored more than 32 entries cannot be redialled: the first-key redial emits nothing. A call of exactly 32 entries replays in full.
- R6: Key 12 or 13, when it is not the first key, stores a pause that is issued as `pause_req`. `pause_long` is 1 after key 12 and 0 after key 13. A number keeps only one pause length, the one set by its last pause key, and every pause in a replay uses it.
- R7: Star/T (key 10) in pulse signalling (`tone_sel`=0) is issued as `pause_req`, and the entries after it carry `out_tone`=1. In tone signalling it is issued on `out_vld` as code 10 with `out_tone`=1.
- R8: Once star/T has switched a call to tone, the switch holds until on-hook is recognised. The next call starts in pulse again.
- R9: Save (key 14) copies the current number into the save store only when no entry is waiting or being dialed; otherwise it is ignored. Recall (key 15) replays the save store when nothing is being dialed, unless the saved number was longer than 32 entries.
- R10: A dialable key that arrives while 32 entries are already waiting for the engine is dropped.
- R11: Keys pressed while on-hook are ignored and no entries are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hook_raw | input | 1 | Hook level, 1 = on-hook |
| tone_sel | input | 1 | Signalling select, 1 = tone, 0 = pulse |
| key_vld | input | 1 | One-cycle strobe of a debounced key event |
| key_code | input | 4 | Key code: 0-9 digits, 10 star/T, 11 hash, 12 long redial/pause, 13 short redial/pause, 14 save, 15 recall |
| dial_done | input | 1 | Engine has finished the last issued entry |
| out_vld | output | 1 | One-cycle strobe of a digit entry |
| out_code | output | 4 | Code of the issued digit entry |
| out_tone | output | 1 | Issued digit is to be sent as tone |
| pause_req | output | 1 | One-cycle request for a pause |
| pause_long | output | 1 | Requested pause is the long one |

## Verification
The bench targets the boundary between 32 and 33 stored entries. A design with an off-by-one there would either refuse a full-length redial or replay a number that had wrapped. It presses the redial key first and not first, so a decoder that ignored key position would pause instead of replaying, or the reverse. It also mixes both pause keys in one number, which catches a design that stores a length per pause. It puts star/T in pulse mode, hangs up and dials again, which exposes a tone latch that is never cleared or one that clears too soon. It glitches the hook for fewer than the filter cycles, presses save while digits are still going out, and holds off `dial_done` until the 33rd queued key. A broken filter would end the call, a careless save would overwrite the stored number, and an unbounded queue would overwrite entries that have not been dialed.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

    typedef logic [3:0] code_t;

    localparam code_t K_STAR     = 4'd10;
    localparam code_t K_HASH     = 4'd11;
    localparam code_t K_RP_LONG  = 4'd12;
    localparam code_t K_RP_SHORT = 4'd13;
    localparam code_t K_SAVE     = 4'd14;
    localparam code_t K_RECALL   = 4'd15;

    // stored entry code for a pause
    localparam code_t E_PAUSE    = 4'd12;

    typedef enum logic {PL_IDLE, PL_WAIT} play_st_t;

    typedef struct packed {
        logic  dig;    // digit entry strobe
        logic  pse;    // pause strobe
        logic  plong;  // long pause
        logic  tone;   // digit as tone
        code_t code;
    } emit_t;

    function automatic logic is_dial_key(code_t k);
        return k <= K_HASH;
    endfunction

    function automatic logic is_rp_key(code_t k);
        return (k == K_RP_LONG) || (k == K_RP_SHORT);
    endfunction

endpackage

// File: rtl/rdb_hook_filt.sv
module rdb_hook_filt #(
    parameter int HOOK_DB_CYC = 4915
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_onhook,
    output logic hk_on,
    output logic offhook_rise
);
    localparam int CW = $clog2(HOOK_DB_CYC + 1);
    localparam logic [CW-1:0] LAST_C = CW'(HOOK_DB_CYC - 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hk_on        <= 1'b1;
            offhook_rise <= 1'b0;
            hi_cnt       <= '0;
        end else begin
            offhook_rise <= 1'b0;
            if (hk_on) begin
                hi_cnt <= '0;
                if (!raw_onhook) begin
                    hk_on        <= 1'b0;
                    offhook_rise <= 1'b1;
                end
            end else if (raw_onhook) begin
                if (hi_cnt == LAST_C) begin
                    hk_on  <= 1'b1;
                    hi_cnt <= '0;
                end else begin
                    hi_cnt <= hi_cnt + 1'b1;
                end
            end else begin
                hi_cnt <= '0;
            end
        end
    end

    // R2: entering on-hook needs the raw level high on the edge before
    p_onhook_needs_high_r2: assert property (@(posedge clk) disable iff (rst)
        (hk_on && !$past(hk_on)) |-> $past(raw_onhook));

    // R2: an off-hook event always leaves the on-hook state
    p_rise_clears_r2: assert property (@(posedge clk) disable iff (rst)
        offhook_rise |-> !hk_on);

endmodule

// File: rtl/rdb_store.sv
module rdb_store
    import rdb_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hk_on,
    input  logic  offhook_rise,
    input  logic  key_vld,
    input  code_t key_code,
    input  logic  busy,
    input  logic  play_take,
    output code_t ent_out,
    output logic  plong_out,
    output logic  pend_nz
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;
    localparam logic [PW-1:0] DEP_C = PW'(DEPTH);

    code_t red_mem [DEPTH];
    code_t sav_mem [DEPTH];

    logic [PW-1:0] wr_cnt, play_cnt, pending;
    logic [PW-1:0] rec_len, prv_len, sav_len;
    logic rec_ovf, prv_ovf, sav_ovf;
    logic rec_plong, prv_plong, sav_plong;
    logic first_key;

    logic  key_ok, dialing, do_redial, do_pause, do_entry, wr_ok;
    logic  do_save, do_recall;
    code_t wr_val;

    always_comb begin
        pending   = wr_cnt - play_cnt;
        dialing   = (pending != '0) || busy;
        key_ok    = key_vld && !hk_on && !offhook_rise;
        do_redial = key_ok && is_rp_key(key_code) && first_key;
        do_pause  = key_ok && is_rp_key(key_code) && !first_key;
        do_entry  = (key_ok && is_dial_key(key_code)) || do_pause;
        wr_ok     = do_entry && (pending < DEP_C);
        wr_val    = do_pause ? E_PAUSE : key_code;
        do_save   = key_ok && (key_code == K_SAVE) && !dialing;
        do_recall = key_ok && (key_code == K_RECALL) && !dialing;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt    <= '0;
            play_cnt  <= '0;
            rec_len   <= '0;
            prv_len   <= '0;
            sav_len   <= '0;
            rec_ovf   <= 1'b0;
            prv_ovf   <= 1'b0;
            sav_ovf   <= 1'b0;
            rec_plong <= 1'b0;
            prv_plong <= 1'b0;
            sav_plong <= 1'b0;
            first_key <= 1'b0;
        end else if (offhook_rise) begin
            prv_len   <= rec_len;
            prv_ovf   <= rec_ovf;
            prv_plong <= rec_plong;
            rec_len   <= '0;
            rec_ovf   <= 1'b0;
            rec_plong <= 1'b0;
            wr_cnt    <= '0;
            play_cnt  <= '0;
            first_key <= 1'b1;
        end else begin
            if (play_take) play_cnt <= play_cnt + 1'b1;
            if (key_ok) first_key <= 1'b0;
            if (wr_ok) begin
                red_mem[wr_cnt[IW-1:0]] <= wr_val;
                wr_cnt <= wr_cnt + 1'b1;
                if (rec_len == DEP_C) rec_ovf <= 1'b1;
                else rec_len <= rec_len + 1'b1;
                if (do_pause) rec_plong <= (key_code == K_RP_LONG);
            end
            if (do_redial && !prv_ovf) begin
                wr_cnt    <= prv_len;
                play_cnt  <= '0;
                rec_len   <= prv_len;
                rec_plong <= prv_plong;
            end
            if (do_save) begin
                for (int i = 0; i < DEPTH; i++) sav_mem[i] <= red_mem[i];
                sav_len   <= rec_len;
                sav_ovf   <= rec_ovf;
                sav_plong <= rec_plong;
            end
            if (do_recall && !sav_ovf) begin
                for (int i = 0; i < DEPTH; i++) red_mem[i] <= sav_mem[i];
                wr_cnt    <= sav_len;
                play_cnt  <= '0;
                rec_len   <= sav_len;
                rec_ovf   <= 1'b0;
                rec_plong <= sav_plong;
            end
        end
    end

    assign ent_out   = red_mem[play_cnt[IW-1:0]];
    assign plong_out = rec_plong;
    assign pend_nz   = (pending != '0);

    // R10: the queue of undialed entries never exceeds the store
    p_pend_cap_r10: assert property (@(posedge clk) disable iff (rst)
        pending <= DEP_C);

    // R5: recorded length saturates at the store depth
    p_len_cap_r5: assert property (@(posedge clk) disable iff (rst)
        rec_len <= DEP_C);

    // R5: an inhibited redial queues nothing
    p_redial_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
        (do_redial && prv_ovf) |=> (wr_cnt == '0));

    // R9: save while dialing leaves the saved length untouched
    p_save_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (key_ok && key_code == K_SAVE && dialing) |=> $stable(sav_len));

endmodule

// File: rtl/rdb_player.sv
module rdb_player
    import rdb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hk_on,
    input  logic  offhook_rise,
    input  logic  pend_nz,
    input  code_t ent_in,
    input  logic  plong_in,
    input  logic  tone_pin,
    input  logic  dial_done,
    output logic  play_take,
    output logic  busy,
    output emit_t em
);
    play_st_t st;
    logic     tone_lat, tone_now;

    assign tone_now  = tone_pin || tone_lat;
    assign play_take = (st == PL_IDLE) && pend_nz && !hk_on && !offhook_rise;
    assign busy      = (st == PL_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PL_IDLE;
            tone_lat <= 1'b0;
            em       <= '0;
        end else begin
            em.dig <= 1'b0;
            em.pse <= 1'b0;
            if (hk_on || offhook_rise) begin
                st <= PL_IDLE;
                if (hk_on) tone_lat <= 1'b0;
            end else begin
                case (st)
                    PL_IDLE: if (play_take) begin
                        st <= PL_WAIT;
                        if (ent_in == E_PAUSE) begin
                            em.pse   <= 1'b1;
                            em.plong <= plong_in;
                        end else if (ent_in == K_STAR && !tone_now) begin
                            em.pse   <= 1'b1;
                            em.plong <= plong_in;
                            tone_lat <= 1'b1;
                        end else begin
                            em.dig  <= 1'b1;
                            em.code <= ent_in;
                            em.tone <= tone_now;
                        end
                    end
                    PL_WAIT: if (dial_done) st <= PL_IDLE;
                    default: st <= PL_IDLE;
                endcase
            end
        end
    end

    // R3: a digit and a pause are never issued together
    p_single_evt_r3: assert property (@(posedge clk) disable iff (rst)
        !(em.dig && em.pse));

    // R3: an issued entry is followed by a wait, never a back-to-back entry
    p_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (em.dig || em.pse) |=> !(em.dig || em.pse));

    // R8: the tone switch holds while the call lasts
    p_tone_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tone_lat && !hk_on) |=> tone_lat);

endmodule

// File: rtl/rdb_redial_buf.sv
module rdb_redial_buf
    import rdb_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int HOOK_DB_CYC = 4915
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hook_raw,
    input  logic       tone_sel,
    input  logic       key_vld,
    input  logic [3:0] key_code,
    input  logic       dial_done,
    output logic       out_vld,
    output logic [3:0] out_code,
    output logic       out_tone,
    output logic       pause_req,
    output logic       pause_long
);
    logic  hk_on, offhook_rise, busy, play_take, plong, pend_nz;
    code_t ent;
    emit_t em;

    rdb_hook_filt #(.HOOK_DB_CYC(HOOK_DB_CYC)) hook_i (
        .clk(clk), .rst(rst), .raw_onhook(hook_raw),
        .hk_on(hk_on), .offhook_rise(offhook_rise)
    );

    rdb_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .hk_on(hk_on), .offhook_rise(offhook_rise),
        .key_vld(key_vld), .key_code(key_code), .busy(busy),
        .play_take(play_take), .ent_out(ent), .plong_out(plong),
        .pend_nz(pend_nz)
    );

    rdb_player player_i (
        .clk(clk), .rst(rst), .hk_on(hk_on), .offhook_rise(offhook_rise),
        .pend_nz(pend_nz), .ent_in(ent), .plong_in(plong),
        .tone_pin(tone_sel), .dial_done(dial_done),
        .play_take(play_take), .busy(busy), .em(em)
    );

    assign out_vld    = em.dig;
    assign out_code   = em.code;
    assign out_tone   = em.tone;
    assign pause_req  = em.pse;
    assign pause_long = em.plong;

    // R11: nothing is issued once on-hook has been in force for a cycle
    p_quiet_onhook_r11: assert property (@(posedge clk) disable iff (rst)
        (hk_on && $past(hk_on)) |-> !(out_vld || pause_req));

endmodule

// File: tb/rdb_redial_buf_tb_top.sv
module rdb_redial_buf_tb_top;
    localparam int HDB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hook_raw = 1'b1;
    logic tone_sel = 1'b0;
    logic key_vld = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic dial_done = 1'b0;
    logic out_vld, out_tone, pause_req, pause_long;
    logic [3:0] out_code;

    always #4 clk = ~clk;

    rdb_redial_buf #(.DEPTH(32), .HOOK_DB_CYC(HDB)) dut_i (
        .clk(clk), .rst(rst), .hook_raw(hook_raw), .tone_sel(tone_sel),
        .key_vld(key_vld), .key_code(key_code), .dial_done(dial_done),
        .out_vld(out_vld), .out_code(out_code), .out_tone(out_tone),
        .pause_req(pause_req), .pause_long(pause_long)
    );

    int n_chk = 0, n_err = 0;
    int ev_k [256];
    int ev_c [256];
    int ev_f [256];
    int n_ev = 0;
    int viol = 0;
    bit outstanding = 0;
    int countdown = 0;
    int resp_dly = 3;
    bit resp_en = 1;
    bit finished = 0;

    // event log and engine model
    always @(negedge clk) begin
        dial_done <= 1'b0;
        if (!rst) begin
            if (out_vld || pause_req) begin
                if (outstanding) viol++;
                outstanding = 1;
                countdown = resp_dly;
                if (n_ev < 256) begin
                    ev_k[n_ev] = pause_req ? 1 : 0;
                    ev_c[n_ev] = pause_req ? 12 : int'(out_code);
                    ev_f[n_ev] = pause_req ? int'(pause_long) : int'(out_tone);
                end
                n_ev++;
            end else if (outstanding && resp_en) begin
                if (countdown > 0) countdown--;
                else begin
                    dial_done <= 1'b1;
                    outstanding = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind 0 digit (flag = tone), kind 1 pause (flag = long)
    task automatic ev(input int idx, input int kind, input int code, input int flag,
                      input string req);
        int a, e;
        a = ev_k[idx] * 1000 + ev_c[idx] * 10 + ev_f[idx];
        e = kind * 1000 + code * 10 + flag;
        chk(a == e, req, a, e);
    endtask

    task automatic press(input int k);
        @(negedge clk);
        key_vld  = 1'b1;
        key_code = 4'(k);
        @(negedge clk);
        key_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        repeat (400) @(negedge clk);
    endtask

    task automatic hang();
        @(negedge clk);
        hook_raw = 1'b1;
        repeat (HDB + 4) @(negedge clk);
    endtask

    task automatic offh();
        @(negedge clk);
        hook_raw = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int mark;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!out_vld && !pause_req, "R1", int'(out_vld | pause_req), 0);

        // R11 keys on-hook are ignored
        press(5);
        repeat (20) @(negedge clk);
        chk(n_ev == 0, "R11", n_ev, 0);

        // R3 normal dialing
        offh();
        mark = n_ev;
        press(1); press(2); press(3); press(11); press(0);
        drain();
        chk(n_ev - mark == 5, "R3", n_ev - mark, 5);
        ev(mark, 0, 1, 0, "R3"); ev(mark + 1, 0, 2, 0, "R3");
        ev(mark + 2, 0, 3, 0, "R3"); ev(mark + 3, 0, 11, 0, "R3");
        ev(mark + 4, 0, 0, 0, "R3");

        // R4 first-key redial
        hang(); offh();
        mark = n_ev;
        press(12);
        drain();
        chk(n_ev - mark == 5, "R4", n_ev - mark, 5);
        for (int i = 0; i < 5; i++) ev(mark + i, 0, ev_c[i], 0, "R4");

        // R6 pauses when not first key
        mark = n_ev;
        press(5); drain();
        press(13); drain();
        press(12); drain();
        chk(n_ev - mark == 3, "R6", n_ev - mark, 3);
        ev(mark, 0, 5, 0, "R6");
        ev(mark + 1, 1, 12, 0, "R6");
        ev(mark + 2, 1, 12, 1, "R6");
        hang(); offh();
        mark = n_ev;
        press(13);
        drain();
        chk(n_ev - mark == 8, "R6", n_ev - mark, 8);
        ev(mark + 4, 0, 0, 0, "R6"); ev(mark + 5, 0, 5, 0, "R6");
        ev(mark + 6, 1, 12, 1, "R6"); ev(mark + 7, 1, 12, 1, "R6");

        // R2 short glitch keeps the call
        @(negedge clk);
        hook_raw = 1'b1;
        repeat (HDB - 2) @(negedge clk);
        hook_raw = 1'b0;
        repeat (3) @(negedge clk);
        mark = n_ev;
        press(7); drain();
        press(12); drain();
        chk(n_ev - mark == 2, "R2", n_ev - mark, 2);
        ev(mark, 0, 7, 0, "R2");
        ev(mark + 1, 1, 12, 1, "R2");
        // R2 long high ends the call, R11 then ignores keys
        hang();
        mark = n_ev;
        press(9); drain();
        chk(n_ev == mark, "R2", n_ev - mark, 0);

        // R7 star in pulse mode
        offh();
        mark = n_ev;
        press(4); press(10); press(6); press(10);
        drain();
        chk(n_ev - mark == 4, "R7", n_ev - mark, 4);
        ev(mark, 0, 4, 0, "R7");
        ev(mark + 1, 1, 12, 0, "R7");
        ev(mark + 2, 0, 6, 1, "R7");
        ev(mark + 3, 0, 10, 1, "R7");
        // R8 next call back in pulse
        hang(); offh();
        mark = n_ev;
        press(6); drain();
        ev(mark, 0, 6, 0, "R8");
        // R7 star in tone mode
        tone_sel = 1'b1;
        mark = n_ev;
        press(10); drain();
        ev(mark, 0, 10, 1, "R7");
        tone_sel = 1'b0;
        hang();

        // R5 exactly 32 entries replay
        offh();
        for (int i = 0; i < 32; i++) press(i % 10);
        drain();
        hang(); offh();
        mark = n_ev;
        press(12);
        drain();
        chk(n_ev - mark == 32, "R5", n_ev - mark, 32);
        for (int i = 0; i < 32; i++) ev(mark + i, 0, i % 10, 0, "R5");
        hang();
        // R5 33 entries inhibit redial
        offh();
        for (int i = 0; i < 33; i++) press(i % 10);
        drain();
        hang(); offh();
        mark = n_ev;
        press(12); drain();
        chk(n_ev == mark, "R5", n_ev - mark, 0);
        press(8); drain();
        chk(n_ev - mark == 1, "R5", n_ev - mark, 1);
        ev(mark, 0, 8, 0, "R5");
        hang();

        // R9 save when idle, ignore while dialing, recall
        offh();
        press(3); press(1); press(4);
        drain();
        press(14);
        hang(); offh();
        press(9); press(9); drain();
        hang(); offh();
        resp_dly = 30;
        press(2); press(7); press(14);
        drain();
        resp_dly = 3;
        hang(); offh();
        mark = n_ev;
        press(15);
        drain();
        chk(n_ev - mark == 3, "R9", n_ev - mark, 3);
        ev(mark, 0, 3, 0, "R9"); ev(mark + 1, 0, 1, 0, "R9");
        ev(mark + 2, 0, 4, 0, "R9");
        hang();

        // R10 queue full drops the 34th key
        resp_en = 0;
        offh();
        mark = n_ev;
        for (int i = 0; i < 34; i++) press(i % 10);
        resp_en = 1;
        drain();
        chk(n_ev - mark == 33, "R10", n_ev - mark, 33);
        ev(mark + 32, 0, 2, 0, "R10");
        ev(mark + 31, 0, 1, 0, "R10");
        hang();

        // R3 no entry issued before the previous one was acknowledged
        chk(viol == 0, "R3", viol, 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule